// File: doc/BRIEF.md
# Platform System I/O Register Bank

This block is a byte-wide bank of control and identification registers that sits on a simple I/O port bus with 16-bit port addresses. It holds three writable registers:

- a processor soft-reset control,
- a system-control byte of four inhibit and mask flags,
- an I/O map type selector.

It also returns two strap values, one for fitted equipment and one for board identity, and a fixed zero for an unused keylock port. Several write-only ports take writes and do nothing with them.

Two of the stored bits drive output lines directly: one resets the processor and one selects a non-contiguous I/O map. A write that asks for little-endian operation cannot be honoured, so it sets a sticky error line. A separate four-byte memory window only accepts aligned full-word accesses. Reads from it return zero, and writes to it are reported as invalid accesses.

Bits are numbered most-significant first: bit n of a register is the mask `1 << (7 - n)`, so bit 7 is the least significant bit. Port reads are registered. Writes take effect at the clock edge that samples them.

Top module: `sysio_regbank`

## Requirements
- R1: While `rst_n` is low, and after it is released until the first write, `io_rdata` is 0x00. The soft-reset output and the error line are low, and the map-select output is high. The system-control register reads 0x00 and the map-type register reads 0x01.
- R2: A read strobe loads `io_rdata` at the next clock edge. With no read strobe, `io_rdata` keeps its value.
- R3: A write to port 0x092 stores only mask 0x01, the soft-reset bit. `cpu_soft_reset` follows that bit from the same edge, and a read of 0x092 returns the stored byte.
- R4: A write to port 0x092 with mask 0x02 set raises `le_mode_err`. The line stays high until reset; later writes do not clear it.
- R5: A write to port 0x81C stores the data ANDed with 0xF0, and a read of 0x81C returns it.
- R6: A write to port 0x850 stores only mask 0x01 and drives `io_map_noncontig` with it. A read of 0x850 returns the stored byte.
- R7: A read of port 0x80C returns the `EQUIP_STRAP` parameter, 0x852 returns `BOARD_ID`, and 0x818 returns 0x00.
- R8: A read of a write-only port (0x808, 0x810, 0x812, 0x814) or of an undecoded port returns 0xFF. A write to a read-only or undecoded port changes no register and no output.
- R9: A read request to the window at word address `PARITY_BASE`, with all four byte enables set and address bits [1:0] zero, gives a one-cycle `mm_ack` at the next edge with `mm_rdata` zero.
- R10: A write request to the window, or a request with any byte enable clear or a misaligned address, gives a one-cycle `mm_err` at the next edge and no ack. A request outside the window gives neither.
- R11: When a read and a write to the same port share a cycle, the read returns the value held before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| io_rd | input | 1 | Port read strobe |
| io_wr | input | 1 | Port write strobe |
| io_addr | input | 16 | Port address |
| io_wdata | input | 8 | Port write data |
| io_rdata | output | 8 | Registered port read data |
| mm_req | input | 1 | Memory access request |
| mm_we | input | 1 | Memory access is a write |
| mm_addr | input | 32 | Memory byte address |
| mm_be | input | 4 | Memory byte enables |
| mm_rdata | output | 32 | Window read data (always zero) |
| mm_ack | output | 1 | Valid window read completed |
| mm_err | output | 1 | Invalid window access |
| cpu_soft_reset | output | 1 | Soft-reset line to the processor |
| io_map_noncontig | output | 1 | Non-contiguous I/O map select |
| le_mode_err | output | 1 | Sticky unsupported-endianness request |

## Verification
Every result is due exactly one clock after the strobe that causes it:
- port read data appears at the edge after `io_rd`;
- the soft-reset, map-select and error lines change at the edge that samples `io_wr`;
- `mm_ack` and `mm_err` pulse at the edge after `mm_req`.

The bench drives strobes on falling edges and advances its reference model on the same rising edge as the design. It compares every output on the following falling edge, when one register stage has passed. Directed reads check their expected byte on the falling edge that ends the read strobe. This lines up with the single stage between strobe and data.

// File: rtl/sysio_pkg.sv
package sysio_pkg;

  // MSB-first bit numbering: bit n is mask 1 << (7 - n)
  function automatic logic [7:0] msb_bit(input int n);
    return 8'(8'h01 << (7 - n));
  endfunction

  localparam logic [7:0] RST_MASK = msb_bit(7);
  localparam logic [7:0] LE_MASK  = msb_bit(6);
  localparam logic [7:0] CTL_MASK = msb_bit(0) | msb_bit(1) | msb_bit(2) | msb_bit(3);
  localparam logic [7:0] MAP_MASK = msb_bit(7);
  localparam logic [7:0] MAP_RESET = MAP_MASK;
  localparam logic [7:0] UNMAPPED_READ = 8'hFF;

  localparam int NUM_PORTS = 10;

  typedef enum logic [3:0] {
    PK_NONE        = 4'd0,
    PK_RESET_CTL   = 4'd1,
    PK_LAMP        = 4'd2,
    PK_EQUIP       = 4'd3,
    PK_LOCK_A      = 4'd4,
    PK_LOCK_B      = 4'd5,
    PK_CACHE_FLUSH = 4'd6,
    PK_KEY         = 4'd7,
    PK_SYS_CTL     = 4'd8,
    PK_MAP_SEL     = 4'd9,
    PK_BOARD       = 4'd10
  } port_kind_e;

  // index i decodes to kind i+1
  localparam logic [15:0] PORT_ADDR [NUM_PORTS] = '{
    16'h0092, 16'h0808, 16'h080C, 16'h0810, 16'h0812,
    16'h0814, 16'h0818, 16'h081C, 16'h0850, 16'h0852
  };

  function automatic logic is_write_only(input port_kind_e k);
    return (k == PK_LAMP) || (k == PK_LOCK_A) || (k == PK_LOCK_B) ||
           (k == PK_CACHE_FLUSH);
  endfunction

endpackage

// File: rtl/sysio_port_decode.sv
module sysio_port_decode
  import sysio_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic [ADDR_W-1:0] addr,
  output port_kind_e        kind
);

  logic [NUM_PORTS-1:0] hit;

  for (genvar gi = 0; gi < NUM_PORTS; gi++) begin : g_cmp
    assign hit[gi] = (addr == ADDR_W'(PORT_ADDR[gi]));
  end

  always_comb begin
    kind = PK_NONE;
    for (int i = 0; i < NUM_PORTS; i++) begin
      if (hit[i]) kind = port_kind_e'(4'(i + 1));
    end
  end

endmodule

// File: rtl/sysio_ctrl_regs.sv
module sysio_ctrl_regs
  import sysio_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  port_kind_e kind,
  input  logic [7:0] wdata,
  output logic [7:0] rst_ctl_q,
  output logic [7:0] sys_ctl_q,
  output logic [7:0] map_sel_q,
  output logic       le_err_q
);

  logic [7:0] rst_ctl_d, sys_ctl_d, map_sel_d;
  logic       le_err_d;
  logic       rst_ctl_en, sys_ctl_en, map_sel_en;

  always_comb begin
    rst_ctl_en = wr_en && (kind == PK_RESET_CTL);
    sys_ctl_en = wr_en && (kind == PK_SYS_CTL);
    map_sel_en = wr_en && (kind == PK_MAP_SEL);
    rst_ctl_d  = wdata & RST_MASK;
    sys_ctl_d  = wdata & CTL_MASK;
    map_sel_d  = wdata & MAP_MASK;
    le_err_d   = le_err_q | (rst_ctl_en && ((wdata & LE_MASK) != 8'h00));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_ctl_q <= 8'h00;
      sys_ctl_q <= 8'h00;
      map_sel_q <= MAP_RESET;
      le_err_q  <= 1'b0;
    end else begin
      if (rst_ctl_en) rst_ctl_q <= rst_ctl_d;
      if (sys_ctl_en) sys_ctl_q <= sys_ctl_d;
      if (map_sel_en) map_sel_q <= map_sel_d;
      le_err_q <= le_err_d;
    end
  end

  a_r3_soft_reset_load: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && kind == PK_RESET_CTL) |=> (rst_ctl_q == ($past(wdata) & RST_MASK)));

  a_r4_le_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    le_err_q |=> le_err_q);

  a_r5_ctl_load: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && kind == PK_SYS_CTL) |=> (sys_ctl_q == ($past(wdata) & CTL_MASK)));

  a_r6_map_load: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && kind == PK_MAP_SEL) |=> (map_sel_q == ($past(wdata) & MAP_MASK)));

  a_r8_no_stray_write: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en) |=> ($stable(rst_ctl_q) && $stable(sys_ctl_q) && $stable(map_sel_q)));

endmodule

// File: rtl/sysio_read_mux.sv
module sysio_read_mux
  import sysio_pkg::*;
#(
  parameter logic [7:0] EQUIP_STRAP = 8'h00,
  parameter logic [7:0] BOARD_ID    = 8'h00
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rd_en,
  input  port_kind_e kind,
  input  logic [7:0] rst_ctl,
  input  logic [7:0] sys_ctl,
  input  logic [7:0] map_sel,
  output logic [7:0] rdata_q
);

  logic [7:0] rdata_d;

  always_comb begin
    case (kind)
      PK_RESET_CTL: rdata_d = rst_ctl;
      PK_EQUIP:     rdata_d = EQUIP_STRAP;
      PK_KEY:       rdata_d = 8'h00;
      PK_SYS_CTL:   rdata_d = sys_ctl;
      PK_MAP_SEL:   rdata_d = map_sel;
      PK_BOARD:     rdata_d = BOARD_ID;
      default:      rdata_d = UNMAPPED_READ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= 8'h00;
    end else if (rd_en) begin
      rdata_q <= rdata_d;
    end
  end

  a_r2_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_en) |=> $stable(rdata_q));

  a_r8_unreadable_ff: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && (kind == PK_NONE || is_write_only(kind))) |=> (rdata_q == 8'hFF));

  a_r7_key_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && kind == PK_KEY) |=> (rdata_q == 8'h00));

endmodule

// File: rtl/sysio_parity_win.sv
module sysio_parity_win #(
  parameter int              MM_ADDR_W   = 32,
  parameter int              MM_DATA_W   = 32,
  parameter logic [31:0]     PARITY_BASE = 32'hBFFF_EFF0
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   mm_req,
  input  logic                   mm_we,
  input  logic [MM_ADDR_W-1:0]   mm_addr,
  input  logic [MM_DATA_W/8-1:0] mm_be,
  output logic [MM_DATA_W-1:0]   mm_rdata,
  output logic                   mm_ack,
  output logic                   mm_err
);

  localparam int BE_W  = MM_DATA_W / 8;
  localparam int OFF_W = $clog2(BE_W);

  logic word_hit, full_word, aligned, ack_d, err_d;

  always_comb begin
    word_hit  = (mm_addr[MM_ADDR_W-1:OFF_W] == PARITY_BASE[MM_ADDR_W-1:OFF_W]);
    aligned   = (mm_addr[OFF_W-1:0] == '0);
    full_word = (mm_be == {BE_W{1'b1}});
    ack_d     = mm_req && word_hit && !mm_we && full_word && aligned;
    err_d     = mm_req && word_hit && (mm_we || !full_word || !aligned);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mm_ack <= 1'b0;
      mm_err <= 1'b0;
    end else begin
      mm_ack <= ack_d;
      mm_err <= err_d;
    end
  end

  // the window never carries data
  assign mm_rdata = '0;

  a_r10_ack_err_excl: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({mm_ack, mm_err}));

  a_r9_ack_from_read: assert property (@(posedge clk) disable iff (!rst_n)
    mm_ack |-> $past(mm_req && !mm_we));

  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!mm_req) |=> (!mm_ack && !mm_err));

endmodule

// File: rtl/sysio_regbank.sv
module sysio_regbank
  import sysio_pkg::*;
#(
  parameter int          ADDR_W      = 16,
  parameter int          MM_ADDR_W   = 32,
  parameter int          MM_DATA_W   = 32,
  parameter logic [7:0]  EQUIP_STRAP = 8'h00,
  parameter logic [7:0]  BOARD_ID    = 8'h00,
  parameter logic [31:0] PARITY_BASE = 32'hBFFF_EFF0
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   io_rd,
  input  logic                   io_wr,
  input  logic [ADDR_W-1:0]      io_addr,
  input  logic [7:0]             io_wdata,
  output logic [7:0]             io_rdata,
  input  logic                   mm_req,
  input  logic                   mm_we,
  input  logic [MM_ADDR_W-1:0]   mm_addr,
  input  logic [MM_DATA_W/8-1:0] mm_be,
  output logic [MM_DATA_W-1:0]   mm_rdata,
  output logic                   mm_ack,
  output logic                   mm_err,
  output logic                   cpu_soft_reset,
  output logic                   io_map_noncontig,
  output logic                   le_mode_err
);

  port_kind_e kind;
  logic [7:0] rst_ctl_q, sys_ctl_q, map_sel_q;

  sysio_port_decode #(.ADDR_W(ADDR_W)) u_decode (
    .addr (io_addr),
    .kind (kind)
  );

  sysio_ctrl_regs u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (io_wr),
    .kind      (kind),
    .wdata     (io_wdata),
    .rst_ctl_q (rst_ctl_q),
    .sys_ctl_q (sys_ctl_q),
    .map_sel_q (map_sel_q),
    .le_err_q  (le_mode_err)
  );

  sysio_read_mux #(.EQUIP_STRAP(EQUIP_STRAP), .BOARD_ID(BOARD_ID)) u_rmux (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_en   (io_rd),
    .kind    (kind),
    .rst_ctl (rst_ctl_q),
    .sys_ctl (sys_ctl_q),
    .map_sel (map_sel_q),
    .rdata_q (io_rdata)
  );

  sysio_parity_win #(
    .MM_ADDR_W  (MM_ADDR_W),
    .MM_DATA_W  (MM_DATA_W),
    .PARITY_BASE(PARITY_BASE)
  ) u_parity (
    .clk      (clk),
    .rst_n    (rst_n),
    .mm_req   (mm_req),
    .mm_we    (mm_we),
    .mm_addr  (mm_addr),
    .mm_be    (mm_be),
    .mm_rdata (mm_rdata),
    .mm_ack   (mm_ack),
    .mm_err   (mm_err)
  );

  assign cpu_soft_reset   = |(rst_ctl_q & RST_MASK);
  assign io_map_noncontig = |(map_sel_q & MAP_MASK);

  a_r3_reset_line: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr && io_addr == ADDR_W'(16'h0092)) |=> (cpu_soft_reset == $past(io_wdata[0])));

  a_r6_map_line: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr && io_addr == ADDR_W'(16'h0850)) |=> (io_map_noncontig == $past(io_wdata[0])));

endmodule

// File: tb/sysio_regbank_bench.sv
`timescale 1ns/1ps
module sysio_regbank_bench;

  localparam logic [7:0]  EQ  = 8'hA5;
  localparam logic [7:0]  BID = 8'h3C;
  localparam logic [31:0] WIN = 32'hBFFF_EFF0;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        io_rd = 1'b0, io_wr = 1'b0;
  logic [15:0] io_addr = '0;
  logic [7:0]  io_wdata = '0;
  logic [7:0]  io_rdata;
  logic        mm_req = 1'b0, mm_we = 1'b0;
  logic [31:0] mm_addr = '0;
  logic [3:0]  mm_be = '0;
  logic [31:0] mm_rdata;
  logic        mm_ack, mm_err, cpu_soft_reset, io_map_noncontig, le_mode_err;

  int total = 0;
  int bad = 0;

  always #2 clk = ~clk;

  sysio_regbank #(.EQUIP_STRAP(EQ), .BOARD_ID(BID), .PARITY_BASE(WIN)) u_sysio_regbank (
    .clk(clk), .rst_n(rst_n), .io_rd(io_rd), .io_wr(io_wr), .io_addr(io_addr),
    .io_wdata(io_wdata), .io_rdata(io_rdata), .mm_req(mm_req), .mm_we(mm_we),
    .mm_addr(mm_addr), .mm_be(mm_be), .mm_rdata(mm_rdata), .mm_ack(mm_ack),
    .mm_err(mm_err), .cpu_soft_reset(cpu_soft_reset),
    .io_map_noncontig(io_map_noncontig), .le_mode_err(le_mode_err)
  );

  // behavioural reference model
  logic [7:0] m_rst, m_ctl, m_map, m_rd;
  logic       m_le, m_ack, m_err;

  function automatic logic [7:0] ref_read(input logic [15:0] a);
    case (a)
      16'h0092: return m_rst;
      16'h080C: return EQ;
      16'h0818: return 8'h00;
      16'h081C: return m_ctl;
      16'h0850: return m_map;
      16'h0852: return BID;
      default:  return 8'hFF;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_rst = 8'h00; m_ctl = 8'h00; m_map = 8'h01; m_rd = 8'h00;
      m_le = 1'b0; m_ack = 1'b0; m_err = 1'b0;
    end else begin
      if (io_rd) m_rd = ref_read(io_addr);   // R11: read sees pre-write value
      if (io_wr) begin
        if (io_addr == 16'h0092) begin
          m_rst = io_wdata & 8'h01;
          if ((io_wdata & 8'h02) != 0) m_le = 1'b1;
        end
        if (io_addr == 16'h081C) m_ctl = io_wdata & 8'hF0;
        if (io_addr == 16'h0850) m_map = io_wdata & 8'h01;
      end
      m_ack = mm_req && (mm_addr[31:2] == WIN[31:2]) && !mm_we &&
              (mm_be == 4'hF) && (mm_addr[1:0] == 2'b00);
      m_err = mm_req && (mm_addr[31:2] == WIN[31:2]) &&
              (mm_we || mm_be != 4'hF || mm_addr[1:0] != 2'b00);
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // cycle-by-cycle comparison, one stage after the sampling edge
  always @(negedge clk) begin
    if (rst_n) begin
      check("R2 rdata model", {24'h0, io_rdata}, {24'h0, m_rd});
      check("R3 soft reset model", {31'h0, cpu_soft_reset}, {31'h0, m_rst[0]});
      check("R4 le err model", {31'h0, le_mode_err}, {31'h0, m_le});
      check("R6 map line model", {31'h0, io_map_noncontig}, {31'h0, m_map[0]});
      check("R9 ack model", {31'h0, mm_ack}, {31'h0, m_ack});
      check("R10 err model", {31'h0, mm_err}, {31'h0, m_err});
      check("R9 rdata zero", mm_rdata, 32'h0);
    end
  end

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    io_wr = 1'b1; io_addr = a; io_wdata = d;
    @(negedge clk);
    io_wr = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a, input logic [7:0] exp, input string tag);
    @(negedge clk);
    io_rd = 1'b1; io_addr = a;
    @(negedge clk);
    io_rd = 1'b0;
    check(tag, {24'h0, io_rdata}, {24'h0, exp});
  endtask

  task automatic mm(input logic [31:0] a, input logic we, input logic [3:0] be,
                    input logic exp_ack, input logic exp_err, input string tag);
    @(negedge clk);
    mm_req = 1'b1; mm_we = we; mm_addr = a; mm_be = be;
    @(negedge clk);
    mm_req = 1'b0;
    check(tag, {30'h0, mm_ack, mm_err}, {30'h0, exp_ack, exp_err});
    @(negedge clk);
    check({tag, " pulse ends"}, {30'h0, mm_ack, mm_err}, 32'h0);
  endtask

  task automatic reset_checks;
    check("R1 rdata", {24'h0, io_rdata}, 32'h0);
    check("R1 soft reset", {31'h0, cpu_soft_reset}, 32'h0);
    check("R1 map line", {31'h0, io_map_noncontig}, 32'h1);
    check("R1 le err", {31'h0, le_mode_err}, 32'h0);
    check("R1 mm idle", {30'h0, mm_ack, mm_err}, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    reset_checks();
    rst_n = 1'b1;
    @(negedge clk);
    reset_checks();
    rd(16'h081C, 8'h00, "R1 sysctl reset");
    rd(16'h0850, 8'h01, "R1 map reset");

    rd(16'h080C, EQ,    "R7 equipment strap");
    rd(16'h0852, BID,   "R7 board id");
    rd(16'h0818, 8'h00, "R7 keylock zero");

    rd(16'h0808, 8'hFF, "R8 write-only 808");
    rd(16'h0810, 8'hFF, "R8 write-only 810");
    rd(16'h0812, 8'hFF, "R8 write-only 812");
    rd(16'h0814, 8'hFF, "R8 write-only 814");
    rd(16'h0123, 8'hFF, "R8 undecoded");
    wr(16'h080C, 8'hFF); wr(16'h0852, 8'hFF); wr(16'h0818, 8'hFF);
    wr(16'h0093, 8'hFF); wr(16'h0851, 8'hFF); wr(16'h0808, 8'hFF);
    check("R8 soft reset untouched", {31'h0, cpu_soft_reset}, 32'h0);
    check("R8 map untouched", {31'h0, io_map_noncontig}, 32'h1);
    rd(16'h080C, EQ,    "R8 strap unchanged");
    rd(16'h081C, 8'h00, "R8 sysctl unchanged");
    rd(16'h0092, 8'h00, "R8 reset reg unchanged");

    wr(16'h0092, 8'hFD);
    check("R3 soft reset set", {31'h0, cpu_soft_reset}, 32'h1);
    check("R4 no le request", {31'h0, le_mode_err}, 32'h0);
    rd(16'h0092, 8'h01, "R3 readback masked");
    wr(16'h0092, 8'h00);
    check("R3 soft reset clear", {31'h0, cpu_soft_reset}, 32'h0);

    wr(16'h081C, 8'hFF);
    rd(16'h081C, 8'hF0, "R5 sysctl mask");
    wr(16'h081C, 8'h5A);
    rd(16'h081C, 8'h50, "R5 sysctl pattern");

    wr(16'h0850, 8'h00);
    check("R6 map low", {31'h0, io_map_noncontig}, 32'h0);
    rd(16'h0850, 8'h00, "R6 map readback");
    wr(16'h0850, 8'hFE);
    check("R6 map upper bits ignored", {31'h0, io_map_noncontig}, 32'h0);
    wr(16'h0850, 8'h01);
    check("R6 map high", {31'h0, io_map_noncontig}, 32'h1);
    rd(16'h0850, 8'h01, "R6 map readback high");

    wr(16'h0092, 8'h02);
    check("R4 le err raised", {31'h0, le_mode_err}, 32'h1);
    check("R4 soft reset stays low", {31'h0, cpu_soft_reset}, 32'h0);
    wr(16'h0092, 8'h00);
    check("R4 le err sticky", {31'h0, le_mode_err}, 32'h1);

    // R11: simultaneous read and write of sysctl (holds 0x50)
    @(negedge clk);
    io_rd = 1'b1; io_wr = 1'b1; io_addr = 16'h081C; io_wdata = 8'hA3;
    @(negedge clk);
    io_rd = 1'b0; io_wr = 1'b0;
    check("R11 old value returned", {24'h0, io_rdata}, 32'h50);
    repeat (3) @(negedge clk);
    check("R2 rdata held", {24'h0, io_rdata}, 32'h50);
    rd(16'h081C, 8'hA0, "R11 new value after");

    mm(WIN,          1'b0, 4'hF, 1'b1, 1'b0, "R9 full-word read");
    mm(WIN + 32'h2,  1'b0, 4'hF, 1'b0, 1'b1, "R10 misaligned read");
    mm(WIN,          1'b0, 4'h3, 1'b0, 1'b1, "R10 partial read");
    mm(WIN,          1'b1, 4'hF, 1'b0, 1'b1, "R10 write rejected");
    mm(WIN + 32'h4,  1'b0, 4'hF, 1'b0, 1'b0, "R10 outside window");
    mm(WIN - 32'h4,  1'b1, 4'hF, 1'b0, 1'b0, "R10 outside below");

    // reset again after state was changed
    wr(16'h0092, 8'h01);
    wr(16'h0850, 8'h00);
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    reset_checks();
    rst_n = 1'b1;
    @(negedge clk);
    reset_checks();
    rd(16'h081C, 8'h00, "R1 sysctl after second reset");
    rd(16'h0092, 8'h00, "R1 reset reg after second reset");

    repeat (2) @(negedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule